// File: doc/BRIEF.md
# Depth-Cascadable FIFO Stage

This block is a first-in first-out queue of 512 nine-bit words with a write strobe, a read strobe and active-low status flags for full, empty and more-than-half-full. It runs either as a standalone queue or as one stage of a ring of identical stages. In a ring, the ring behaves as a single queue whose depth is the sum of the stage depths. The strobes and the write data are shared by all stages. The read data is taken from the stage that currently holds the read right.

The right to accept writes and the right to serve reads move between stages as tokens. A stage raises `xout` for one cycle when an accepted write lands in its highest address, and again when an accepted read takes its highest address. `xout` of each stage feeds `xin` of the next stage, and the last stage feeds the first. The `first_n` strap picks the stage that owns both tokens after reset. The `EXPAND` parameter picks the mode. With `EXPAND` = 0 the stage is standalone, `xin` is tied low and the stage keeps both rights at all times.

Top module: `cascade_fifo`

## Requirements
- R1: Standalone, accepted words come out in the order they were written. Read data is registered and changes in the cycle after the clock edge that accepts the read.
- R2: After reset the stage holds no words: `empty_n`=0, `full_n`=1, `half_n`=1, `dout`=0.
- R3: A write strobe while full and a read strobe while empty are ignored. The stored words and pointers do not change, and `dout` holds its value.
- R4: `full_n` is 0 exactly when 512 words are stored, and `empty_n` is 0 exactly when none are stored.
- R5: Standalone, `half_n` goes to 0 on the edge of the write that takes the count above 256. It returns to 1 on the edge of the read that brings the count back to 256 or fewer.
- R6: Standalone (`EXPAND`=0), `xout` stays 0 and the stage always holds both the write right and the read right.
- R7: In a ring, the stage with `first_n`=0 holds both rights after reset, and every stage with `first_n`=1 holds neither. A stage without the write right ignores write strobes. A stage without the read right ignores read strobes and keeps `dout` unchanged.
- R8: In a ring, `xout` is 1 during the cycle in which an accepted write targets address 511, or an accepted read takes address 511. The stage gives up the matching right at that edge.
- R9: Each one-cycle `xin` pulse grants a right, starting from the write right after reset and then alternating read, write, read, and so on.
- R10: In a ring, `half_n` is held at 1.
- R11: A ring of stages, with composite flags formed as the OR of the stages' active-low flags, behaves as one queue of 512 words per stage, including across repeated wraps of the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| din | input | 9 | Write data |
| dout | output | 9 | Registered read data |
| full_n | output | 1 | Full flag, active low |
| empty_n | output | 1 | Empty flag, active low |
| half_n | output | 1 | More-than-half flag, active low, standalone only |
| first_n | input | 1 | Strap, 0 marks the stage that starts with both rights |
| xin | input | 1 | Right-grant pulse from the previous stage |
| xout | output | 1 | Right-handoff pulse to the next stage |

## Verification
The hardest situation to reach is the ring wrapping more than once. A stage must then take back a right from the last stage while it still holds unread words. The write right and read right must also stay in alternating order across many handoffs. The bench drives a two-stage ring through interleaved bursts of writes and reads, followed by a long random mix weighted toward writes. This pushes each stage's pointers past address 511 several times, while a queue model predicts every output word, the composite flags and every handoff pulse. The standalone stage is held around the 256/257 boundary, and is also kept at full and at empty while strobes continue.

// File: rtl/cascade_fifo.sv
module cascade_fifo #(
  parameter int WIDTH  = 9,
  parameter int DEPTH  = 512,
  parameter bit EXPAND = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full_n,
  output logic             empty_n,
  output logic             half_n,
  input  logic             first_n,
  input  logic             xin,
  output logic             xout
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [CW-1:0] HALFC = CW'(DEPTH / 2);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic wtok_q, rtok_q, grant_rd;
  logic wtok, rtok, wr_ok, rd_ok, w_last, r_last;

  assign wtok   = EXPAND ? wtok_q : 1'b1;
  assign rtok   = EXPAND ? rtok_q : 1'b1;
  assign wr_ok  = wr_en && wtok && (cnt != FULLC);
  assign rd_ok  = rd_en && rtok && (cnt != '0);
  assign w_last = wr_ok && (wptr == LAST);
  assign r_last = rd_ok && (rptr == LAST);
  assign xout   = EXPAND && (w_last || r_last);

  assign full_n  = (cnt != FULLC);
  assign empty_n = (cnt != '0);
  assign half_n  = EXPAND ? 1'b1 : !(cnt > HALFC);

  always_ff @(posedge clk)
    if (wr_ok) mem[wptr] <= din;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      dout     <= '0;
      wtok_q   <= !first_n;
      rtok_q   <= !first_n;
      grant_rd <= 1'b0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) begin
        dout <= mem[rptr];
        rptr <= rptr + 1'b1;
      end
      if (wr_ok && !rd_ok)      cnt <= cnt + 1'b1;
      else if (rd_ok && !wr_ok) cnt <= cnt - 1'b1;
      if (w_last) wtok_q <= 1'b0;
      if (r_last) rtok_q <= 1'b0;
      if (xin) begin
        if (grant_rd) rtok_q <= 1'b1;
        else          wtok_q <= 1'b1;
        grant_rd <= !grant_rd;
      end
    end
  end

  p_wr_blocked_r3: assert property (@(posedge clk) disable iff (rst)
    !full_n |=> $stable(wptr));
  p_rd_blocked_r3: assert property (@(posedge clk) disable iff (rst)
    !empty_n |=> ($stable(rptr) && $stable(dout)));
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(!full_n && !empty_n));
  p_half_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
    !half_n |-> empty_n);
  p_no_pass_single_r6: assert property (@(posedge clk) disable iff (rst)
    (EXPAND != 1'b0) || !xout);
  p_idle_reader_r7: assert property (@(posedge clk) disable iff (rst)
    !rtok |=> $stable(dout));
  p_single_pass_r8: assert property (@(posedge clk) disable iff (rst)
    !(w_last && r_last));
  p_grant_r9: assert property (@(posedge clk) disable iff (rst)
    xin |=> (wtok || rtok));
  p_no_half_chain_r10: assert property (@(posedge clk) disable iff (rst)
    (EXPAND == 1'b0) || half_n);
endmodule

// File: tb/test_cascade_fifo.sv
module test_cascade_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int D = 512;

  logic clk = 0, rst = 1;
  always #(CLK_PERIOD / 2) clk = !clk;

  int checks = 0, errors = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // standalone stage
  logic a_wr = 0, a_rd = 0; logic [8:0] a_din = 0, a_dout;
  logic a_full, a_empty, a_half, a_xout;
  cascade_fifo #(.EXPAND(1'b0)) i_cascade_fifo (
    .clk, .rst, .wr_en(a_wr), .rd_en(a_rd), .din(a_din), .dout(a_dout),
    .full_n(a_full), .empty_n(a_empty), .half_n(a_half),
    .first_n(1'b0), .xin(1'b0), .xout(a_xout));

  // two-stage ring
  logic b_wr = 0, b_rd = 0; logic [8:0] b_din = 0, d0, d1;
  logic f0, f1, e0, e1, h0, h1, x0, x1;
  cascade_fifo #(.EXPAND(1'b1)) i_cascade_fifo_s0 (
    .clk, .rst, .wr_en(b_wr), .rd_en(b_rd), .din(b_din), .dout(d0),
    .full_n(f0), .empty_n(e0), .half_n(h0), .first_n(1'b0), .xin(x1), .xout(x0));
  cascade_fifo #(.EXPAND(1'b1)) i_cascade_fifo_s1 (
    .clk, .rst, .wr_en(b_wr), .rd_en(b_rd), .din(b_din), .dout(d1),
    .full_n(f1), .empty_n(e1), .half_n(h1), .first_n(1'b1), .xin(x0), .xout(x1));

  int qa[$], qb[$];
  int exp_a = 0, exp_b0 = 0, exp_b1 = 0;
  longint wcnt = 0, rcnt = 0;

  task automatic step_a(bit w, bit r, int d, string req);
    bit aw, ar;
    a_wr = w; a_rd = r; a_din = 9'(d);
    aw = w && qa.size() < D;
    ar = r && qa.size() > 0;
    @(posedge clk);
    if (ar) exp_a = qa.pop_front();
    if (aw) qa.push_back(d & 511);
    #1;
    check({req, " R1 dout"}, a_dout, exp_a);
    check("R4 full_n", a_full, qa.size() != D);
    check("R4 empty_n", a_empty, qa.size() != 0);
    check("R5 half_n", a_half, !(qa.size() > D / 2));
    check("R6 xout", a_xout, 0);
    @(negedge clk);
  endtask

  task automatic step_b(bit w, bit r, int d, string req);
    bit aw, ar; int rs;
    b_wr = w; b_rd = r; b_din = 9'(d);
    aw = w && qb.size() < 2 * D;
    ar = r && qb.size() > 0;
    rs = int'((rcnt / D) % 2);
    #1;
    // R8: handoff pulses in the cycle of the last-address access
    check("R8 xout s0", x0, (aw && wcnt % (2*D) == D-1) || (ar && rcnt % (2*D) == D-1));
    check("R8 xout s1", x1, (aw && wcnt % (2*D) == 2*D-1) || (ar && rcnt % (2*D) == 2*D-1));
    @(posedge clk);
    if (ar) begin
      if (rs == 0) exp_b0 = qb.pop_front(); else exp_b1 = qb.pop_front();
      rcnt++;
    end
    if (aw) begin qb.push_back(d & 511); wcnt++; end
    #1;
    check({req, " R11 dout s0"}, d0, exp_b0);
    check({req, " R7 R11 dout s1"}, d1, exp_b1);
    check("R11 composite full", f0 | f1, qb.size() != 2 * D);
    check("R11 composite empty", e0 | e1, qb.size() != 0);
    check("R10 half_n", h0 & h1, 1);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    check("R2 empty_n", a_empty, 0);
    check("R2 full_n", a_full, 1);
    check("R2 half_n", a_half, 1);
    check("R2 dout", a_dout, 0);
    check("R7 s1 empty after reset", e1, 0);

    // standalone: fill across the half boundary to full
    for (int i = 0; i < D; i++) step_a(1, 0, i * 7 + 3, "R5 fill");
    for (int i = 0; i < 4; i++) step_a(1, 0, 99, "R3 write when full");
    step_a(1, 1, 77, "R3 write and read at full");
    for (int i = 0; i < D + 4; i++) step_a(0, 1, 0, "R3 drain past empty");
    step_a(1, 1, 5, "R3 write and read at empty");
    step_a(0, 1, 0, "R1 read");
    for (int i = 0; i < 256; i++) step_a(1, 0, i ^ 85, "R5 prefill");
    for (int i = 0; i < 3000; i++)
      step_a(($urandom % 2) == 1, ($urandom % 2) == 1, int'($urandom % 512), "R5 random");

    // ring: stage 1 must ignore strobes until it gets rights (R7, R9)
    for (int i = 0; i < 400; i++) begin
      step_b(1, 0, i + 11, "R7 first stage writes");
      check("R7 s1 ignores writes", e1, 0);
    end
    for (int i = 0; i < 700; i++) step_b(1, 0, i * 3, "R9 write across stages");
    for (int i = 0; i < 600; i++) step_b(0, 1, 0, "R9 read across stages");
    for (int i = 0; i < 900; i++) step_b(1, 0, i * 5 + 1, "R9 refill past wrap");
    for (int i = 0; i < 6000; i++)
      step_b(($urandom % 10) < 6, ($urandom % 10) < 5, int'($urandom % 512), "R11 random");
    for (int i = 0; i < 2 * D + 8; i++) step_b(0, 1, 0, "R11 drain");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule